// File: doc/BRIEF.md
# Write-Protection Unlock Sequence Detector

This block watches every write strobe that reaches a byte-wide non-volatile array and decides whether the write may proceed to the page-load sequencer. It keeps a protection flag that survives an ordinary reset. Three command writes in a fixed order, all inside the byte-load window, set the flag and open a window for exactly one page load. Six command writes in a fixed order clear the flag. The page sequencer reports through `page_done` that the load and its programming have finished, and this closes the window.

While the flag is clear, ordinary writes go straight through. While it is set, only the writes made inside an open window go through. Writes that form a command step are used up by the detector and never forwarded. A write that breaks a sequence, or a pause longer than the window between two steps, sends the detector back to idle and leaves the flag as it was.

The flag has its own clear input, `blank_n`, which models a part fresh from the factory. The detector reset `rst_n` returns the sequence logic to idle and does not touch the flag.

Top module: `wprot_seq_detect`

## Requirements
- R1: While `rst_n` is low, `wr_allow` is 0 and the detector is idle. While `blank_n` is low, `prot_on` is 0. A pulse on `rst_n` alone leaves `prot_on` unchanged.
- R2: While `prot_on` is 0, a write that is not a command step raises `wr_allow` for exactly the one cycle after its strobe. `wr_allow` is never high unless a strobe was sampled on the edge before.
- R3: The enable pattern is data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. On the third write, `prot_on` becomes 1 and the page window opens, whether or not the flag was set before. None of the three writes raises `wr_allow`.
- R4: While the window is open, every write raises `wr_allow`, command-like values included. A `page_done` pulse closes the window, and `prot_on` is 1 afterwards.
- R5: While `prot_on` is 1 and the window is closed, no write raises `wr_allow`.
- R6: The disable pattern is 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. After the sixth write, `prot_on` is 0. None of the six writes raises `wr_allow`. `prot_on` changes only on a sampled strobe, or through `blank_n`.
- R7: A write that does not match the next expected step returns the detector to idle and leaves `prot_on` unchanged. It is forwarded when unprotected and blocked when protected.
- R8: If `LOAD_WIN` cycles pass with no strobe while a sequence is partly entered, the detector returns to idle, and the next step of that sequence is then treated as an ordinary write. Gaps shorter than `LOAD_WIN` cycles are accepted.
- R9: A `page_done` pulse while the window is closed has no effect on `prot_on` or on which writes are forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the sequence logic |
| blank_n | input | 1 | Active-low asynchronous clear of the protection flag |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | 15 | Write address |
| wr_data | input | 8 | Write data |
| page_done | input | 1 | Pulse from the sequencer: page load and programming complete |
| wr_allow | output | 1 | Registered pulse: the sampled write goes to the page sequencer |
| prot_on | output | 1 | Protection flag |

## Verification
The checker module covers the rules that hold on every cycle:
- a forwarded write always follows a strobe;
- a protected write is forwarded only from an open window;
- the flag moves only on a strobe;
- the window only opens with the flag set;
- a partly entered sequence never outlives `LOAD_WIN` idle cycles.

Several properties depend on data values and ordering, and only the bench's scenarios can show them:
- that the exact command values are recognised;
- that a wrong fourth disable step aborts the sequence;
- that a timed-out step falls through as data;
- that a stray `page_done` changes nothing;
- that the flag survives a detector reset.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  localparam int ADDR_W = 15;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] CMD_ADDR_A = 15'h5555;
  localparam logic [ADDR_W-1:0] CMD_ADDR_B = 15'h2AAA;

  typedef enum logic [2:0] {
    ST_IDLE, ST_E1, ST_E2, ST_D3, ST_D4, ST_D5, ST_OPEN
  } wp_state_e;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_AA_A, CMD_55_B, CMD_A0_A, CMD_80_A, CMD_20_A
  } wp_cmd_e;

  // Map one write onto the command alphabet.
  function automatic wp_cmd_e classify(input logic [ADDR_W-1:0] a,
                                       input logic [DATA_W-1:0] d);
    wp_cmd_e c;
    c = CMD_NONE;
    if (a == CMD_ADDR_A) begin
      case (d)
        8'hAA:   c = CMD_AA_A;
        8'hA0:   c = CMD_A0_A;
        8'h80:   c = CMD_80_A;
        8'h20:   c = CMD_20_A;
        default: c = CMD_NONE;
      endcase
    end else if (a == CMD_ADDR_B && d == 8'h55) begin
      c = CMD_55_B;
    end
    return c;
  endfunction

  // True when command c is the expected next step from state s.
  function automatic logic step_ok(input wp_state_e s, input wp_cmd_e c);
    case (s)
      ST_IDLE: return c == CMD_AA_A;
      ST_E1:   return c == CMD_55_B;
      ST_E2:   return (c == CMD_A0_A) || (c == CMD_80_A);
      ST_D3:   return c == CMD_AA_A;
      ST_D4:   return c == CMD_55_B;
      ST_D5:   return c == CMD_20_A;
      default: return 1'b0;
    endcase
  endfunction

  // Successor state for an accepted step.
  function automatic wp_state_e step_next(input wp_state_e s, input wp_cmd_e c);
    case (s)
      ST_IDLE: return ST_E1;
      ST_E1:   return ST_E2;
      ST_E2:   return (c == CMD_A0_A) ? ST_OPEN : ST_D3;
      ST_D3:   return ST_D4;
      ST_D4:   return ST_D5;
      default: return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/wprot_cmd_decode.sv
module wprot_cmd_decode
  import wprot_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output wp_cmd_e           cmd
);
  always_comb cmd = classify(addr, data);
endmodule

// File: rtl/wprot_gap_timer.sv
module wprot_gap_timer #(
  parameter int LOAD_WIN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic stb,
  output logic expired
);
  localparam int CW = $clog2(LOAD_WIN) + 1;
  localparam logic [CW-1:0] LIMIT = CW'(LOAD_WIN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!armed || stb)  cnt <= '0;
    else if (cnt != LIMIT)   cnt <= cnt + 1'b1;
  end

  assign expired = armed && !stb && (cnt == LIMIT);
endmodule

// File: rtl/wprot_flag.sv
module wprot_flag (
  input  logic clk,
  input  logic blank_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge blank_n) begin
    if (!blank_n)    flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/wprot_seq_detect.sv
module wprot_seq_detect
  import wprot_pkg::*;
#(
  parameter int LOAD_WIN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blank_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              page_done,
  output logic              wr_allow,
  output logic              prot_on
);

  wp_state_e state, state_nx;
  wp_cmd_e   cmd;

  // Named internal events, visible to the bound checker.
  logic win_open, mid_seq, hit, ev_unlock, ev_disable, ev_abort, ev_timeout, pass_now;

  wprot_cmd_decode u_dec (.addr(wr_addr), .data(wr_data), .cmd(cmd));

  assign win_open   = (state == ST_OPEN);
  assign mid_seq    = !win_open && (state != ST_IDLE);
  assign hit        = step_ok(state, cmd);
  assign ev_unlock  = wr_stb && (state == ST_E2) && (cmd == CMD_A0_A);
  assign ev_disable = wr_stb && (state == ST_D5) && (cmd == CMD_20_A);
  assign ev_abort   = wr_stb && !win_open && !hit;
  assign pass_now   = wr_stb && (win_open || (ev_abort && !prot_on));

  wprot_gap_timer #(.LOAD_WIN(LOAD_WIN)) u_gap (
    .clk(clk), .rst_n(rst_n), .armed(mid_seq), .stb(wr_stb), .expired(ev_timeout)
  );

  wprot_flag u_flag (
    .clk(clk), .blank_n(blank_n), .set_i(ev_unlock), .clr_i(ev_disable), .flag_o(prot_on)
  );

  always_comb begin
    state_nx = state;
    if (wr_stb) begin
      if (win_open) state_nx = ST_OPEN;
      else if (hit) state_nx = step_next(state, cmd);
      else          state_nx = ST_IDLE;
    end else if (win_open && page_done) begin
      state_nx = ST_IDLE;
    end else if (ev_timeout) begin
      state_nx = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      wr_allow <= 1'b0;
    end else begin
      state    <= state_nx;
      wr_allow <= pass_now;
    end
  end

endmodule

// File: rtl/wprot_seq_detect_chk.sv
module wprot_seq_detect_chk #(
  parameter int LOAD_WIN = 16
) (
  input logic clk,
  input logic rst_n,
  input logic blank_n,
  input logic wr_stb,
  input logic wr_allow,
  input logic prot_on,
  input logic win_open,
  input logic mid_seq
);
  localparam int GW = $clog2(LOAD_WIN + 1) + 1;
  logic [GW-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 gap <= '0;
    else if (mid_seq && !wr_stb) gap <= gap + 1'b1;
    else                        gap <= '0;
  end

  p_pass_after_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_allow |-> $past(wr_stb));

  p_block_protected_r5: assert property (@(posedge clk) disable iff (!rst_n || !blank_n)
    (wr_allow && $past(prot_on)) |-> $past(win_open));

  p_open_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n || !blank_n)
    $rose(win_open) |-> prot_on);

  p_flag_moves_on_stb_r6: assert property (@(posedge clk) disable iff (!rst_n || !blank_n)
    (prot_on != $past(prot_on)) |-> $past(wr_stb));

  p_open_needs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_open && !wr_stb) |=> !win_open);

  p_gap_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mid_seq |-> (gap < GW'(LOAD_WIN)));

endmodule

bind wprot_seq_detect wprot_seq_detect_chk #(.LOAD_WIN(LOAD_WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .wr_stb(wr_stb),
  .wr_allow(wr_allow), .prot_on(prot_on), .win_open(win_open), .mid_seq(mid_seq)
);

// File: tb/tb_wprot_seq_detect.sv
`timescale 1ns/1ps
module tb_wprot_seq_detect;
  localparam int LOAD_WIN = 16;

  logic        clk = 1'b0;
  logic        rst_n, blank_n, wr_stb, page_done;
  logic [14:0] wr_addr;
  logic [7:0]  wr_data;
  logic        wr_allow, prot_on;

  int n_chk = 0;
  int n_fail = 0;
  bit    q_pass[$];
  string q_tag[$];
  logic  took = 1'b0;

  always #5 clk = ~clk;

  wprot_seq_detect #(.LOAD_WIN(LOAD_WIN)) dut (
    .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .page_done(page_done),
    .wr_allow(wr_allow), .prot_on(prot_on)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: one expected forwarding decision per sampled strobe.
  always @(posedge clk) took <= wr_stb & rst_n;

  always @(negedge clk) begin
    if (took) begin
      if (q_pass.size() == 0) chk(1'b0, "scoreboard empty", 1, 0);
      else begin
        bit    e;
        string t;
        e = q_pass.pop_front();
        t = q_tag.pop_front();
        chk(wr_allow == e, t, int'(wr_allow), int'(e));
      end
    end else if (rst_n && wr_allow) begin
      chk(1'b0, "R2 spurious wr_allow", 1, 0);
    end
  end

  task automatic wr(input logic [14:0] a, input logic [7:0] d, input bit p, input string tag);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    q_pass.push_back(p); q_tag.push_back(tag);
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic chk_prot(input bit e, input string tag);
    @(negedge clk);
    chk(prot_on == e, tag, int'(prot_on), int'(e));
  endtask

  task automatic done_pulse();
    @(negedge clk); page_done = 1'b1;
    @(negedge clk); page_done = 1'b0;
  endtask

  task automatic enable_seq(input string tag);
    wr(15'h5555, 8'hAA, 1'b0, tag);
    wr(15'h2AAA, 8'h55, 1'b0, tag);
    wr(15'h5555, 8'hA0, 1'b0, tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired (all R)", 0, 1);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; blank_n = 1'b0; wr_stb = 1'b0; page_done = 1'b0;
    wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk(prot_on == 1'b0, "R1 blank clears flag", int'(prot_on), 0);
    chk(wr_allow == 1'b0, "R1 allow low in reset", int'(wr_allow), 0);
    blank_n = 1'b1; rst_n = 1'b1;

    // R2: unprotected data passes, including a non-command value at a command address
    wr(15'h1234, 8'h11, 1'b1, "R2 plain write");
    wr(15'h5555, 8'h33, 1'b1, "R2 non-command at 0x5555");

    // R3: enable from unprotected
    enable_seq("R3 enable step not forwarded");
    chk_prot(1'b1, "R3 flag set after enable");

    // R4: window forwards all, command-like too
    wr(15'h0100, 8'h01, 1'b1, "R4 window data");
    wr(15'h5555, 8'hAA, 1'b1, "R4 command-like data in window");
    wr(15'h2AAA, 8'h55, 1'b1, "R4 command-like data in window");
    done_pulse();
    chk_prot(1'b1, "R4 protected after page done");

    // R5: protected blocks
    wr(15'h0200, 8'h22, 1'b0, "R5 protected write blocked");

    // R9: stray page_done
    done_pulse();
    wr(15'h0201, 8'h23, 1'b0, "R9 stray page_done opened nothing");
    chk_prot(1'b1, "R9 flag unchanged");

    // R1: detector reset keeps flag
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk_prot(1'b1, "R1 rst_n keeps flag");

    // R7: mismatch while protected
    wr(15'h5555, 8'hAA, 1'b0, "R7 step1");
    wr(15'h2AAA, 8'h77, 1'b0, "R7 protected mismatch blocked");
    wr(15'h5555, 8'hA0, 1'b0, "R7 orphan third step blocked");
    wr(15'h0300, 8'h30, 1'b0, "R7 no window after abort");
    chk_prot(1'b1, "R7 flag unchanged");

    // R8: timeout while protected
    wr(15'h5555, 8'hAA, 1'b0, "R8 step1");
    wr(15'h2AAA, 8'h55, 1'b0, "R8 step2");
    repeat (LOAD_WIN + 3) @(negedge clk);
    wr(15'h5555, 8'hA0, 1'b0, "R8 late step blocked");
    wr(15'h0400, 8'h40, 1'b0, "R8 no window after timeout");

    // R8: short gaps accepted
    wr(15'h5555, 8'hAA, 1'b0, "R8 step1 short gap");
    repeat (5) @(negedge clk);
    wr(15'h2AAA, 8'h55, 1'b0, "R8 step2 short gap");
    repeat (5) @(negedge clk);
    wr(15'h5555, 8'hA0, 1'b0, "R8 step3 short gap");
    wr(15'h0410, 8'h41, 1'b1, "R8 window opened after short gaps");
    done_pulse();

    // R7: wrong fourth disable step while protected
    wr(15'h5555, 8'hAA, 1'b0, "R7 d1");
    wr(15'h2AAA, 8'h55, 1'b0, "R7 d2");
    wr(15'h5555, 8'h80, 1'b0, "R7 d3");
    wr(15'h2AAA, 8'h99, 1'b0, "R7 wrong d4 blocked");
    chk_prot(1'b1, "R7 flag kept after bad disable");

    // R6: disable
    wr(15'h5555, 8'hAA, 1'b0, "R6 d1");
    wr(15'h2AAA, 8'h55, 1'b0, "R6 d2");
    wr(15'h5555, 8'h80, 1'b0, "R6 d3");
    wr(15'h5555, 8'hAA, 1'b0, "R6 d4");
    wr(15'h2AAA, 8'h55, 1'b0, "R6 d5");
    wr(15'h5555, 8'h20, 1'b0, "R6 d6");
    chk_prot(1'b0, "R6 flag cleared");

    // R7: unprotected mismatch passes
    wr(15'h5555, 8'hAA, 1'b0, "R7 step1 unprotected");
    wr(15'h0010, 8'h12, 1'b1, "R7 unprotected mismatch passes");
    chk_prot(1'b0, "R7 flag still clear");

    // R8: unprotected timeout, late step passes as data
    wr(15'h5555, 8'hAA, 1'b0, "R8 step1 unprotected");
    repeat (LOAD_WIN + 3) @(negedge clk);
    wr(15'h2AAA, 8'h55, 1'b1, "R8 late step passes as data");

    // R3 again from unprotected, then close
    enable_seq("R3 second enable");
    chk_prot(1'b1, "R3 flag set again");
    wr(15'h0500, 8'h50, 1'b1, "R4 window write");
    done_pulse();
    wr(15'h0501, 8'h51, 1'b0, "R5 blocked after close");

    // R1: blank clears
    @(negedge clk); blank_n = 1'b0;
    @(negedge clk); blank_n = 1'b1;
    chk_prot(1'b0, "R1 blank clears flag later");
    wr(15'h0600, 8'h60, 1'b1, "R2 passes after blank");

    repeat (3) @(negedge clk);
    chk(q_pass.size() == 0, "scoreboard drained (R2)", q_pass.size(), 0);
    summary();
    $finish;
  end
endmodule